// File: doc/BRIEF.md
# Register File with 16-bit Pointer Pairs

This block is the general-purpose register store of an 8-bit processor core. It holds thirty-two 8-bit registers. Two read ports are combinational, and one 8-bit write port commits on the clock edge. An ALU can therefore fetch both operands and store its result within the same cycle. A read of a register that is being written in the same cycle returns the value it held before that edge, because there is no bypass.

The six highest registers also act as three 16-bit address pointers. Each pointer can be read as one 16-bit word. A dedicated pointer write port replaces both bytes of one pointer at a single edge, which suits post-increment and pre-decrement addressing. The topmost pointer is also driven out at all times for indexing constant tables in program memory.

The register file also answers a data-space access port at the lowest data addresses, below the I/O region that begins at 0x20. Loads and stores that use plain data addresses can therefore reach the registers.

Top module: `rf_pointer_file`

## Requirements
- R1: While `rstN` is low, every register is cleared to 0x00, and it stays zero until it is written.
- R2: `rdDataA` and `rdDataB` show the current contents of the registers selected by `rdAddrA` and `rdAddrB`, with no clock latency. Both ports may select the same register.
- R3: When `wrEn` is high, `wrData` is stored into register `wrAddr` at the rising edge. A read of that register before the edge returns the old value.
- R4: Pointer selection codes are 0 for X = {r27,r26}, 1 for Y = {r29,r28} and 2 for Z = {r31,r30}. The low byte is the even register. `ptrRdData` shows the selected pair, and the code 3 reads 0x0000.
- R5: When `ptrWrEn` is high with a code from 0 to 2, both bytes of that pair take `ptrWrData` at one edge. The code 3 writes no register.
- R6: `zPtr` always equals {r31,r30}.
- R7: `dataHit` is high exactly when `dataAddr` is below 0x20. In that case `dataRdData` shows register `dataAddr[4:0]`; otherwise it is 0x00.
- R8: When `dataWrEn` is high and `dataHit` is high, `dataWrData` is stored into register `dataAddr[4:0]` at the edge. A data write to an address of 0x20 or above changes no register.
- R9: When writers target the same register in one cycle, the pointer write takes priority over the 8-bit write, and the 8-bit write takes priority over the data-space write. Writers that target different registers all take effect at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| rdAddrA | input | 5 | Operand A register index |
| rdDataA | output | 8 | Operand A value |
| rdAddrB | input | 5 | Operand B register index |
| rdDataB | output | 8 | Operand B value |
| wrEn | input | 1 | 8-bit result write enable |
| wrAddr | input | 5 | Result register index |
| wrData | input | 8 | Result value |
| ptrWrEn | input | 1 | Pointer write enable |
| ptrWrSel | input | 2 | Pointer write select (0 X, 1 Y, 2 Z) |
| ptrWrData | input | 16 | New 16-bit pointer value |
| ptrRdSel | input | 2 | Pointer read select |
| ptrRdData | output | 16 | Selected 16-bit pointer value |
| zPtr | output | 16 | Permanent view of pointer Z |
| dataAddr | input | 16 | Data-space address |
| dataWrEn | input | 1 | Data-space store enable |
| dataWrData | input | 8 | Data-space store value |
| dataRdData | output | 8 | Data-space load value when mapped here |
| dataHit | output | 1 | Address falls in the register window |

## Verification
A corrupted register does not show by itself. It becomes visible only when some read path selects it, so the bench reads every register through both operand ports, the pointer port and the data window after each write pattern. A wrong pair mapping or a wrong write-priority decision shows at the edge that follows the write. It appears on `zPtr` at once for Z and on the selected read port for the other registers. A missing bypass, or a bypass added by mistake, shows only in the cycle before the edge, so the same-cycle reads are sampled there.

// File: rtl/rf_pkg.sv
package rf_pkg;

  // Which writer supplies a register's next value.
  typedef enum logic [1:0] {
    SRC_DATA   = 2'd0,
    SRC_BYTE   = 2'd1,
    SRC_PTR_LO = 2'd2,
    SRC_PTR_HI = 2'd3
  } srcSel_t;

  // Per-register strobe handed from control to datapath.
  typedef struct packed {
    logic    we;
    srcSel_t src;
  } regStrobe_t;

endpackage

// File: rtl/rf_ctrl.sv
module rf_ctrl
  import rf_pkg::*;
#(
  parameter int NUM_REGS    = 32,
  parameter int NUM_PTRS    = 3,
  parameter int PTR_BASE    = 26,
  parameter int DATA_ADDR_W = 16,
  localparam int ADDR_W     = $clog2(NUM_REGS),
  localparam int PTR_SEL_W  = $clog2(NUM_PTRS + 1)
) (
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic                   ptrWrEn,
  input  logic [PTR_SEL_W-1:0]   ptrWrSel,
  input  logic [DATA_ADDR_W-1:0] dataAddr,
  input  logic                   dataWrEn,
  output logic                   dataHit,
  output regStrobe_t [NUM_REGS-1:0] strobes
);

  logic ptrWrValid;

  assign dataHit    = dataAddr < DATA_ADDR_W'(NUM_REGS);
  assign ptrWrValid = ptrWrEn && (ptrWrSel < PTR_SEL_W'(NUM_PTRS));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic byteHit;
    logic dataWrHit;
    logic ptrHit;
    logic ptrIsHigh;

    assign byteHit   = wrEn && (wrAddr == ADDR_W'(i));
    assign dataWrHit = dataWrEn && dataHit && (dataAddr[ADDR_W-1:0] == ADDR_W'(i));

    if (i >= PTR_BASE && i < PTR_BASE + 2 * NUM_PTRS) begin : g_pair
      localparam int PAIR_IDX = (i - PTR_BASE) / 2;
      assign ptrHit    = ptrWrValid && (ptrWrSel == PTR_SEL_W'(PAIR_IDX));
      assign ptrIsHigh = ((i - PTR_BASE) % 2) == 1;
    end else begin : g_plain
      assign ptrHit    = 1'b0;
      assign ptrIsHigh = 1'b0;
    end

    // Fixed priority: pointer, then 8-bit result, then data-space store.
    always_comb begin
      strobes[i].we  = ptrHit || byteHit || dataWrHit;
      if (ptrHit)       strobes[i].src = ptrIsHigh ? SRC_PTR_HI : SRC_PTR_LO;
      else if (byteHit) strobes[i].src = SRC_BYTE;
      else              strobes[i].src = SRC_DATA;
    end
  end

endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
  import rf_pkg::*;
#(
  parameter int NUM_REGS    = 32,
  parameter int DATA_W      = 8,
  parameter int NUM_PTRS    = 3,
  parameter int PTR_BASE    = 26,
  parameter int DATA_ADDR_W = 16,
  localparam int ADDR_W     = $clog2(NUM_REGS),
  localparam int PTR_SEL_W  = $clog2(NUM_PTRS + 1),
  localparam int PTR_W      = 2 * DATA_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  regStrobe_t [NUM_REGS-1:0] strobes,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [PTR_W-1:0]       ptrWrData,
  input  logic [DATA_W-1:0]      dataWrData,
  input  logic [ADDR_W-1:0]      rdAddrA,
  input  logic [ADDR_W-1:0]      rdAddrB,
  input  logic [PTR_SEL_W-1:0]   ptrRdSel,
  input  logic [DATA_ADDR_W-1:0] dataAddr,
  input  logic                   dataHit,
  output logic [DATA_W-1:0]      rdDataA,
  output logic [DATA_W-1:0]      rdDataB,
  output logic [PTR_W-1:0]       ptrRdData,
  output logic [PTR_W-1:0]       zPtr,
  output logic [DATA_W-1:0]      dataRdData
);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [PTR_W-1:0]  ptrVal [NUM_PTRS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_store
    logic [DATA_W-1:0] nextVal;

    always_comb begin
      unique case (strobes[i].src)
        SRC_PTR_LO: nextVal = ptrWrData[DATA_W-1:0];
        SRC_PTR_HI: nextVal = ptrWrData[PTR_W-1:DATA_W];
        SRC_BYTE:   nextVal = wrData;
        default:    nextVal = dataWrData;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              regs[i] <= '0;
      else if (strobes[i].we) regs[i] <= nextVal;
    end
  end

  for (genvar p = 0; p < NUM_PTRS; p++) begin : g_ptr
    assign ptrVal[p] = {regs[PTR_BASE + 2 * p + 1], regs[PTR_BASE + 2 * p]};
  end

  // Operand reads are straight from storage: no same-cycle bypass.
  assign rdDataA = regs[rdAddrA];
  assign rdDataB = regs[rdAddrB];

  always_comb begin
    ptrRdData = '0;
    for (int p = 0; p < NUM_PTRS; p++) begin
      if (ptrRdSel == PTR_SEL_W'(p)) ptrRdData = ptrVal[p];
    end
  end

  assign zPtr       = ptrVal[NUM_PTRS-1];
  assign dataRdData = dataHit ? regs[dataAddr[ADDR_W-1:0]] : '0;

endmodule

// File: rtl/rf_pointer_file.sv
module rf_pointer_file
  import rf_pkg::*;
#(
  parameter int NUM_REGS    = 32,
  parameter int DATA_W      = 8,
  parameter int NUM_PTRS    = 3,
  parameter int PTR_BASE    = 26,
  parameter int DATA_ADDR_W = 16,
  localparam int ADDR_W     = $clog2(NUM_REGS),
  localparam int PTR_SEL_W  = $clog2(NUM_PTRS + 1),
  localparam int PTR_W      = 2 * DATA_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      rdAddrA,
  output logic [DATA_W-1:0]      rdDataA,
  input  logic [ADDR_W-1:0]      rdAddrB,
  output logic [DATA_W-1:0]      rdDataB,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [DATA_W-1:0]      wrData,
  input  logic                   ptrWrEn,
  input  logic [PTR_SEL_W-1:0]   ptrWrSel,
  input  logic [PTR_W-1:0]       ptrWrData,
  input  logic [PTR_SEL_W-1:0]   ptrRdSel,
  output logic [PTR_W-1:0]       ptrRdData,
  output logic [PTR_W-1:0]       zPtr,
  input  logic [DATA_ADDR_W-1:0] dataAddr,
  input  logic                   dataWrEn,
  input  logic [DATA_W-1:0]      dataWrData,
  output logic [DATA_W-1:0]      dataRdData,
  output logic                   dataHit
);

  regStrobe_t [NUM_REGS-1:0] strobes;

  rf_ctrl #(
    .NUM_REGS(NUM_REGS), .NUM_PTRS(NUM_PTRS),
    .PTR_BASE(PTR_BASE), .DATA_ADDR_W(DATA_ADDR_W)
  ) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr),
    .ptrWrEn(ptrWrEn), .ptrWrSel(ptrWrSel),
    .dataAddr(dataAddr), .dataWrEn(dataWrEn),
    .dataHit(dataHit), .strobes(strobes)
  );

  rf_datapath #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_PTRS(NUM_PTRS),
    .PTR_BASE(PTR_BASE), .DATA_ADDR_W(DATA_ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrData(wrData), .ptrWrData(ptrWrData), .dataWrData(dataWrData),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .ptrRdSel(ptrRdSel),
    .dataAddr(dataAddr), .dataHit(dataHit),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .ptrRdData(ptrRdData),
    .zPtr(zPtr), .dataRdData(dataRdData)
  );

endmodule

// File: rtl/rf_pointer_file_checker.sv
module rf_pointer_file_checker #(
  parameter int NUM_REGS    = 32,
  parameter int DATA_W      = 8,
  parameter int NUM_PTRS    = 3,
  parameter int DATA_ADDR_W = 16,
  localparam int ADDR_W     = $clog2(NUM_REGS),
  localparam int PTR_SEL_W  = $clog2(NUM_PTRS + 1),
  localparam int PTR_W      = 2 * DATA_W
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [ADDR_W-1:0]      rdAddrA,
  input logic [DATA_W-1:0]      rdDataA,
  input logic                   wrEn,
  input logic [ADDR_W-1:0]      wrAddr,
  input logic [DATA_W-1:0]      wrData,
  input logic                   ptrWrEn,
  input logic [PTR_SEL_W-1:0]   ptrWrSel,
  input logic [PTR_W-1:0]       ptrWrData,
  input logic [PTR_SEL_W-1:0]   ptrRdSel,
  input logic [PTR_W-1:0]       ptrRdData,
  input logic [PTR_W-1:0]       zPtr,
  input logic [DATA_ADDR_W-1:0] dataAddr,
  input logic                   dataWrEn,
  input logic [DATA_W-1:0]      dataRdData,
  input logic                   dataHit
);

  localparam logic [PTR_SEL_W-1:0] Z_SEL   = PTR_SEL_W'(NUM_PTRS - 1);
  localparam logic [ADDR_W-1:0]    Z_LO_IX = ADDR_W'(NUM_REGS - 2);

  logic zTouched;
  assign zTouched = (ptrWrEn && ptrWrSel == Z_SEL) ||
                    (wrEn && wrAddr >= Z_LO_IX) ||
                    (dataWrEn && dataHit && dataAddr[ADDR_W-1:0] >= Z_LO_IX);

  // R5 / R9: a pointer write to Z lands whole, whatever else is writing.
  a_r5_ptr_write_z: assert property (@(posedge clk) disable iff (!rstN)
    (ptrWrEn && ptrWrSel == Z_SEL) |=> zPtr == $past(ptrWrData));

  // R3: an unopposed 8-bit write to the Z low byte shows up next cycle.
  a_r3_byte_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == Z_LO_IX && !(ptrWrEn && ptrWrSel == Z_SEL))
      |=> zPtr[DATA_W-1:0] == $past(wrData));

  // R6: Z holds its value when nobody writes its registers.
  a_r6_z_stable: assert property (@(posedge clk) disable iff (!rstN)
    !zTouched |=> $stable(zPtr));

  // R6 / R2: the operand port and the Z view agree on r30.
  a_r6_z_matches_read: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == Z_LO_IX) |-> rdDataA == zPtr[DATA_W-1:0]);

  // R4: selecting Z on the pointer read port matches the dedicated view.
  a_r4_ptr_read_z: assert property (@(posedge clk) disable iff (!rstN)
    (ptrRdSel == Z_SEL) |-> ptrRdData == zPtr);

  // R7: the data window and operand port agree on the same register.
  a_r7_window_read: assert property (@(posedge clk) disable iff (!rstN)
    (dataHit && dataAddr[ADDR_W-1:0] == rdAddrA) |-> dataRdData == rdDataA);

endmodule

bind rf_pointer_file rf_pointer_file_checker #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_PTRS(NUM_PTRS), .DATA_ADDR_W(DATA_ADDR_W)
) u_checker (
  .clk(clk), .rstN(rstN), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
  .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .ptrWrEn(ptrWrEn), .ptrWrSel(ptrWrSel), .ptrWrData(ptrWrData),
  .ptrRdSel(ptrRdSel), .ptrRdData(ptrRdData), .zPtr(zPtr),
  .dataAddr(dataAddr), .dataWrEn(dataWrEn), .dataRdData(dataRdData),
  .dataHit(dataHit)
);

// File: tb/tb_rf_pointer_file.sv
module tb_rf_pointer_file;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [7:0]  rdDataA, rdDataB, wrData = '0, dataWrData = '0, dataRdData;
  logic        wrEn = 1'b0, ptrWrEn = 1'b0, dataWrEn = 1'b0, dataHit;
  logic [1:0]  ptrWrSel = '0, ptrRdSel = '0;
  logic [15:0] ptrWrData = '0, ptrRdData, zPtr, dataAddr = '0;

  int checks = 0;
  int failures = 0;
  logic [7:0] model [32];

  always #2 clk = ~clk;

  rf_pointer_file dut (
    .clk(clk), .rstN(rstN),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ptrWrEn(ptrWrEn), .ptrWrSel(ptrWrSel), .ptrWrData(ptrWrData),
    .ptrRdSel(ptrRdSel), .ptrRdData(ptrRdData), .zPtr(zPtr),
    .dataAddr(dataAddr), .dataWrEn(dataWrEn), .dataWrData(dataWrData),
    .dataRdData(dataRdData), .dataHit(dataHit)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Apply pending writes to the model in priority order, then take the edge.
  task automatic edgeStep();
    logic [7:0] nxt [32];
    for (int i = 0; i < 32; i++) nxt[i] = model[i];
    if (dataWrEn && dataAddr < 16'h20) nxt[dataAddr[4:0]] = dataWrData;
    if (wrEn) nxt[wrAddr] = wrData;
    if (ptrWrEn && ptrWrSel != 2'd3) begin
      nxt[26 + 2 * ptrWrSel]     = ptrWrData[7:0];
      nxt[26 + 2 * ptrWrSel + 1] = ptrWrData[15:8];
    end
    @(posedge clk);
    for (int i = 0; i < 32; i++) model[i] = nxt[i];
    #1;
    wrEn = 1'b0; ptrWrEn = 1'b0; dataWrEn = 1'b0;
  endtask

  task automatic sweepAll(input string tag);
    for (int i = 0; i < 32; i++) begin
      rdAddrA = 5'(i); rdAddrB = 5'(31 - i); dataAddr = 16'(i);
      #1;
      check(rdDataA == model[i], {tag, " R2 portA"}, rdDataA, model[i]);
      check(rdDataB == model[31 - i], {tag, " R2 portB"}, rdDataB, model[31 - i]);
      check(dataRdData == model[i] && dataHit, {tag, " R7 window"}, dataRdData, model[i]);
    end
    for (int p = 0; p < 4; p++) begin
      logic [15:0] e;
      ptrRdSel = 2'(p);
      e = (p == 3) ? 16'h0 : {model[27 + 2 * p], model[26 + 2 * p]};
      #1;
      check(ptrRdData == e, {tag, " R4 pointer read"}, ptrRdData, e);
    end
    check(zPtr == {model[31], model[30]}, {tag, " R6 zPtr"}, zPtr, {model[31], model[30]});
  endtask

  initial begin : watchdog
    #(200000 * 4);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    #5 rstN = 1'b1;
    @(negedge clk);
    sweepAll("reset R1");

    // R3: fill every register through the 8-bit port, old value visible before edge.
    for (int i = 0; i < 32; i++) begin
      wrEn = 1'b1; wrAddr = 5'(i); wrData = 8'(i * 37 + 11); rdAddrA = 5'(i);
      #1;
      check(rdDataA == model[i], "R3 no bypass", rdDataA, model[i]);
      edgeStep();
      check(rdDataA == 8'(i * 37 + 11), "R3 written", rdDataA, 8'(i * 37 + 11));
    end
    sweepAll("fill");

    // R1: reset again after content exists.
    rstN = 1'b0; #1;
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    sweepAll("R1 reclear");
    rstN = 1'b1;
    @(negedge clk);

    // R5: pointer writes for all codes, including the unused one.
    for (int p = 0; p < 4; p++) begin
      ptrWrEn = 1'b1; ptrWrSel = 2'(p); ptrWrData = 16'(16'hA15C + p * 16'h1111);
      edgeStep();
      sweepAll("R5 pointer write");
    end

    // R8: data-space writes below and above the window.
    for (int a = 0; a < 64; a += 3) begin
      dataWrEn = 1'b1; dataAddr = 16'(a); dataWrData = 8'(a ^ 8'h5A);
      #1;
      check(dataHit == (a < 32), "R7 hit flag", dataHit, a < 32);
      if (a >= 32) check(dataRdData == 8'h00, "R7 miss reads zero", dataRdData, 0);
      edgeStep();
    end
    dataWrEn = 1'b1; dataAddr = 16'h8003; dataWrData = 8'hEE;
    edgeStep();
    sweepAll("R8 data writes");

    // R9: collisions on the same register and on different registers.
    for (int p = 0; p < 3; p++) begin
      ptrWrEn = 1'b1; ptrWrSel = 2'(p); ptrWrData = 16'(16'h1234 + p);
      wrEn = 1'b1; wrAddr = 5'(26 + 2 * p + 1); wrData = 8'hC3;
      dataWrEn = 1'b1; dataAddr = 16'(26 + 2 * p); dataWrData = 8'h3C;
      edgeStep();
      sweepAll("R9 ptr wins");
    end
    wrEn = 1'b1; wrAddr = 5'd7; wrData = 8'h77;
    dataWrEn = 1'b1; dataAddr = 16'd7; dataWrData = 8'h99;
    edgeStep();
    sweepAll("R9 byte over data");
    ptrWrEn = 1'b1; ptrWrSel = 2'd0; ptrWrData = 16'hBEEF;
    wrEn = 1'b1; wrAddr = 5'd3; wrData = 8'h33;
    dataWrEn = 1'b1; dataAddr = 16'd30; dataWrData = 8'h44;
    edgeStep();
    sweepAll("R9 disjoint");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule